// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Router

This block gathers the six status conditions of an SPI controller into sticky flag bits. Each condition has its own request-enable bit. A condition raises its request only while both its flag and its enable are set.

Four of the conditions can only raise interrupts. The other two are the transmit-fill condition and the receive-drain condition. Each of these has a direction-select bit that sends its request either to an interrupt line or to a dedicated DMA request line. All individual interrupt lines are also combined into one global interrupt.

Software uses the block through three inputs:
- A configuration write port loads the enable and direction bits.
- A write-1-to-clear strobe removes flags.
- The DMA engine acknowledges a serviced request on a separate input, which also clears the flag that raised it.

Top module: `spi_req_router`

## Requirements
- R1: After a synchronous active-low reset, all flags, enables and direction selects are 0, and every request output is low. Events that arrive before any configuration write set flags but raise no request.
- R2: A 1 on `evt_pulse[i]` sets flag `i`, visible on `flag_q[i]` one cycle later. The flag stays set until it is cleared. Condition index map: 0 end of queue, 1 transmit fill, 2 transfer complete, 3 transmit underflow, 4 receive drain, 5 receive overflow.
- R3: When `clr_we` is 1, each flag whose `clr_mask` bit is 1 is cleared on the next cycle. Flags whose mask bit is 0 are left unchanged.
- R4: When an event and a clear (write-1 or DMA acknowledge) hit the same flag in the same cycle, the event wins and the flag is set.
- R5: `irq_line[i]` equals flag AND enable for conditions 0, 2, 3 and 5. The same holds for conditions 1 and 4 while they are steered to interrupt.
- R6: While condition 1 (or 4) is steered to DMA, `fill_dma_req` (or `drain_dma_req`) equals its flag AND enable, and its `irq_line` bit stays 0.
- R7: `irq_any` is 1 exactly when at least one bit of `irq_line` is 1. A DMA-steered condition therefore never raises it.
- R8: While the fill (drain) condition is steered to DMA, `fill_dma_ack` (`drain_dma_ack`) clears flag 1 (4) on the next cycle. While it is steered to interrupt, the acknowledge has no effect.
- R9: A `cfg_wdata` write with `cfg_we` = 1 takes effect from the next cycle. Bits [5:0] are the per-condition enables. Bit 6 steers fill to DMA when 1. Bit 7 steers drain to DMA when 1. With `cfg_we` = 0 the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 6 | Per-condition event pulses |
| clr_we | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 6 | Flags to clear when `clr_we` is 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Enables [5:0], fill DMA select [6], drain DMA select [7] |
| fill_dma_ack | input | 1 | DMA acknowledge for the fill request |
| drain_dma_ack | input | 1 | DMA acknowledge for the drain request |
| flag_q | output | 6 | Sticky condition flags |
| irq_line | output | 6 | Individual interrupt request lines |
| irq_any | output | 1 | Global interrupt, OR of `irq_line` |
| fill_dma_req | output | 1 | DMA request from the fill condition |
| drain_dma_req | output | 1 | DMA request from the drain condition |

## Verification
The bench builds the block with its default of six conditions, which gives an eight-bit configuration word. This small size makes an exhaustive sweep possible. The bench tries all 256 configurations against all 64 flag patterns and predicts every interrupt line, both DMA requests and the global interrupt arithmetically. Each pattern is loaded by raising events together with a full clear, so the event-over-clear priority is exercised on every step. Directed sequences cover reset, stickiness, partial clears, acknowledge in both directions, and a write with the strobe low.

// File: rtl/spi_rr_pkg.sv
// Package: shared constants for the SPI request router.
// Holds the condition count and the bit positions that software and the
// DMA engine rely on. Other modules derive their widths from these.
package spi_rr_pkg;
    localparam int N_COND     = 6;  // number of status conditions
    localparam int COND_EOQ   = 0;  // end of queue
    localparam int COND_FILL  = 1;  // transmit FIFO fill (DMA capable)
    localparam int COND_DONE  = 2;  // transfer complete
    localparam int COND_UNDR  = 3;  // transmit underflow
    localparam int COND_DRAIN = 4;  // receive FIFO drain (DMA capable)
    localparam int COND_OVFL  = 5;  // receive overflow
endpackage

// File: rtl/spi_rr_cfg.sv
// Module: spi_rr_cfg
// Holds the per-condition request enables and the two direction selects.
// It turns the selects into a per-condition "steered to DMA" vector.
// Assumes the write word carries the enables in its low bits and the two
// selects directly above them.
module spi_rr_cfg #(
    parameter int N_COND     = spi_rr_pkg::N_COND,
    parameter int FILL_IDX   = spi_rr_pkg::COND_FILL,
    parameter int DRAIN_IDX  = spi_rr_pkg::COND_DRAIN,
    localparam int CFG_W     = N_COND + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [N_COND-1:0] en_q,
    output logic [N_COND-1:0] dma_steer
);
    localparam int SEL_FILL_BIT  = N_COND;
    localparam int SEL_DRAIN_BIT = N_COND + 1;

    logic sel_fill_q;
    logic sel_drain_q;

    // Load enables and selects on a write strobe; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= '0;
            sel_fill_q  <= 1'b0;
            sel_drain_q <= 1'b0;
        end else if (cfg_we) begin
            en_q        <= cfg_wdata[N_COND-1:0];
            sel_fill_q  <= cfg_wdata[SEL_FILL_BIT];
            sel_drain_q <= cfg_wdata[SEL_DRAIN_BIT];
        end
    end

    // Expand the two selects into a per-condition DMA-steer vector.
    always_comb begin
        dma_steer            = '0;
        dma_steer[FILL_IDX]  = sel_fill_q;
        dma_steer[DRAIN_IDX] = sel_drain_q;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(en_q) && $stable(dma_steer)); // R9
endmodule

// File: rtl/spi_rr_flags.sv
// Module: spi_rr_flags
// Keeps one sticky flag per condition. An event sets its flag. A clear
// request (write-1-to-clear or DMA acknowledge) resets it, and an event
// in the same cycle takes priority over the clear.
// Assumes the clear vectors are already qualified by their strobes.
module spi_rr_flags #(
    parameter int N_COND = spi_rr_pkg::N_COND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] set_vec,
    input  logic [N_COND-1:0] clr_vec,
    input  logic [N_COND-1:0] ack_vec,
    output logic [N_COND-1:0] flag_q
);
    logic [N_COND-1:0] flag_d;

    // Next flag state: drop cleared bits, then let events override.
    always_comb begin
        flag_d = (flag_q & ~(clr_vec | ack_vec)) | set_vec;
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < N_COND; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]); // R4
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] && !set_vec[i] |=> !flag_q[i]); // R3
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] && !clr_vec[i] && !ack_vec[i] |=> flag_q[i]); // R2
    end
endmodule

// File: rtl/spi_rr_route.sv
// Module: spi_rr_route
// Purely combinational routing. Each enabled flag goes to its interrupt
// line unless the condition is steered to DMA; in that case it drives the
// DMA request instead. The module also produces the global interrupt and
// turns DMA acknowledges into clear requests.
// Assumes only the fill and drain bits of the steer vector can be set.
module spi_rr_route #(
    parameter int N_COND    = spi_rr_pkg::N_COND,
    parameter int FILL_IDX  = spi_rr_pkg::COND_FILL,
    parameter int DRAIN_IDX = spi_rr_pkg::COND_DRAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] flag_q,
    input  logic [N_COND-1:0] en_q,
    input  logic [N_COND-1:0] dma_steer,
    input  logic              fill_ack,
    input  logic              drain_ack,
    output logic [N_COND-1:0] irq_line,
    output logic              irq_any,
    output logic              fill_req,
    output logic              drain_req,
    output logic [N_COND-1:0] ack_vec
);
    logic [N_COND-1:0] active;

    // Requests exist only where a flag is set and its enable is on.
    always_comb begin
        active   = flag_q & en_q;
        irq_line = active & ~dma_steer;
        irq_any  = |irq_line;
    end

    // DMA requests and acknowledge-driven clears for the steered conditions.
    always_comb begin
        fill_req           = active[FILL_IDX]  & dma_steer[FILL_IDX];
        drain_req          = active[DRAIN_IDX] & dma_steer[DRAIN_IDX];
        ack_vec            = '0;
        ack_vec[FILL_IDX]  = fill_ack  & dma_steer[FILL_IDX];
        ack_vec[DRAIN_IDX] = drain_ack & dma_steer[DRAIN_IDX];
    end

    AST_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && irq_line[FILL_IDX])); // R6
    AST_DRAIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drain_req && irq_line[DRAIN_IDX])); // R6
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> !irq_any); // R7
endmodule

// File: rtl/spi_req_router.sv
// Module: spi_req_router (top)
// Joins three parts: the configuration register, the sticky flag bank and
// the request router. Together they turn SPI condition pulses into
// interrupt lines, a global interrupt and two DMA requests.
// Assumes event pulses and clears are synchronous to clk.
module spi_req_router #(
    parameter int N_COND     = spi_rr_pkg::N_COND,
    localparam int CFG_W     = N_COND + 2,
    localparam int FILL_IDX  = spi_rr_pkg::COND_FILL,
    localparam int DRAIN_IDX = spi_rr_pkg::COND_DRAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] evt_pulse,
    input  logic              clr_we,
    input  logic [N_COND-1:0] clr_mask,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              fill_dma_ack,
    input  logic              drain_dma_ack,
    output logic [N_COND-1:0] flag_q,
    output logic [N_COND-1:0] irq_line,
    output logic              irq_any,
    output logic              fill_dma_req,
    output logic              drain_dma_req
);
    logic [N_COND-1:0] en_q;
    logic [N_COND-1:0] dma_steer;
    logic [N_COND-1:0] clr_vec;
    logic [N_COND-1:0] ack_vec;

    // Qualify the write-1-to-clear mask with its strobe.
    always_comb begin
        clr_vec = clr_we ? clr_mask : '0;
    end

    spi_rr_cfg #(.N_COND(N_COND), .FILL_IDX(FILL_IDX), .DRAIN_IDX(DRAIN_IDX)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .en_q      (en_q),
        .dma_steer (dma_steer)
    );

    spi_rr_flags #(.N_COND(N_COND)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_pulse),
        .clr_vec (clr_vec),
        .ack_vec (ack_vec),
        .flag_q  (flag_q)
    );

    spi_rr_route #(.N_COND(N_COND), .FILL_IDX(FILL_IDX), .DRAIN_IDX(DRAIN_IDX)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_q    (flag_q),
        .en_q      (en_q),
        .dma_steer (dma_steer),
        .fill_ack  (fill_dma_ack),
        .drain_ack (drain_dma_ack),
        .irq_line  (irq_line),
        .irq_any   (irq_any),
        .fill_req  (fill_dma_req),
        .drain_req (drain_dma_req),
        .ack_vec   (ack_vec)
    );

    AST_FILL_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_dma_ack && fill_dma_req && !evt_pulse[FILL_IDX] |=> !flag_q[FILL_IDX]); // R8
    AST_DRAIN_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drain_dma_ack && drain_dma_req && !evt_pulse[DRAIN_IDX] |=> !flag_q[DRAIN_IDX]); // R8
endmodule

// File: tb/spi_req_router_bench.sv
`timescale 1ns/1ps
module spi_req_router_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_pulse = '0;
    logic       clr_we = 1'b0;
    logic [5:0] clr_mask = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       fill_dma_ack = 1'b0;
    logic       drain_dma_ack = 1'b0;
    logic [5:0] flag_q;
    logic [5:0] irq_line;
    logic       irq_any;
    logic       fill_dma_req;
    logic       drain_dma_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_req_router u_spi_req_router (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .clr_we(clr_we),
        .clr_mask(clr_mask), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .fill_dma_ack(fill_dma_ack), .drain_dma_ack(drain_dma_ack),
        .flag_q(flag_q), .irq_line(irq_line), .irq_any(irq_any),
        .fill_dma_req(fill_dma_req), .drain_dma_req(drain_dma_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus at a falling edge and return at the next one.
    task automatic cyc(input logic [5:0] ev, input logic [5:0] cm,
                       input logic fa, input logic da,
                       input logic we, input logic [7:0] wd);
        evt_pulse = ev; clr_we = |cm; clr_mask = cm;
        fill_dma_ack = fa; drain_dma_ack = da; cfg_we = we; cfg_wdata = wd;
        @(negedge clk);
        evt_pulse = '0; clr_we = 1'b0; clr_mask = '0;
        fill_dma_ack = 1'b0; drain_dma_ack = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "flags", flag_q, 0);
        chk("R1", "irq_line", irq_line, 0);
        chk("R1", "irq_any", irq_any, 0);
        chk("R1", "dma", {fill_dma_req, drain_dma_req}, 0);
        // R2: events set flags; R1: enables reset to 0 so no requests
        cyc(6'h3F, 0, 0, 0, 0, 0);
        chk("R2", "flags set", flag_q, 6'h3F);
        chk("R1", "irq after events", {irq_any, irq_line}, 0);
        chk("R1", "dma after events", {fill_dma_req, drain_dma_req}, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R2", "sticky", flag_q, 6'h3F);
        // R3: partial write-1-to-clear
        cyc(0, 6'h05, 0, 0, 0, 0);
        chk("R3", "w1c", flag_q, 6'h3A);
        // R4: event wins over clear
        cyc(6'h03, 6'h03, 0, 0, 0, 0);
        chk("R4", "event vs clear", flag_q, 6'h3B);
        // R8/R9: enable all, fill to DMA, drain to interrupt
        cyc(0, 0, 0, 0, 1, 8'h7F);
        chk("R6", "fill req", fill_dma_req, 1);
        chk("R6", "fill irq bit", irq_line[1], 0);
        chk("R9", "irq lines", irq_line, 6'h39);
        cyc(0, 0, 1, 0, 0, 0);
        chk("R8", "fill ack clears", flag_q, 6'h39);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R8", "drain ack ignored", flag_q, 6'h39);
        cyc(6'h02, 0, 1, 0, 0, 0);
        chk("R8", "event beats ack", flag_q, 6'h3B);
        // R9: data without strobe is ignored, then a real write
        cyc(0, 0, 0, 0, 0, 8'h00);
        chk("R9", "no strobe", {fill_dma_req, irq_line}, {1'b1, 6'h39});
        cyc(0, 0, 0, 0, 1, 8'h00);
        chk("R9", "write zero", {irq_any, fill_dma_req, irq_line}, 0);
        // Exhaustive sweep: R5, R6, R7 and R4 via event+full clear
        for (int c = 0; c < 256; c++) begin
            cyc(0, 0, 0, 0, 1, c[7:0]);
            for (int p = 0; p < 64; p++) begin
                logic [5:0] en, steer, exp_irq;
                cyc(p[5:0], 6'h3F, 0, 0, 0, 0);
                en = c[5:0];
                steer = {1'b0, c[7], 2'b00, c[6], 1'b0};
                exp_irq = p[5:0] & en & ~steer;
                chk("R4", "sweep flags", flag_q, p[5:0]);
                chk("R5", "sweep irq_line", irq_line, exp_irq);
                chk("R7", "sweep irq_any", irq_any, |exp_irq);
                chk("R6", "sweep fill req", fill_dma_req, p[1] & en[1] & c[6]);
                chk("R6", "sweep drain req", drain_dma_req, p[4] & en[4] & c[7]);
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule